// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the bus clock and marks every serial-clock edge with a one-cycle strobe. The shift logic uses these strobes to launch and sample data bits. A single mode input picks between two divide laws:

- **Linear mode:** an even divider controlled by an 8-bit divisor.
- **Power-of-two mode:** an exponential divider controlled by a 4-bit exponent. Larger divisor values are clamped to the maximum exponent.

The divider produces clock edges only while the controller is enabled and a frame is in progress. Otherwise the serial clock rests low and the internal counter sits at zero. Polarity inversion and the data shift register live elsewhere.

Mode and divisor are captured into the block only while the controller is disabled. Software therefore sets them, then enables the controller, and any later change has no effect until the next disable. All control pins are plain levels. There is no streamed data at this block's edge, so it has no valid/ready handshake.

Top module: `spi_clkdiv`

## Requirements
- R1: While reset is asserted, `sclk`, `lead_stb` and `trail_stb` are all low.
- R2: Whenever `enable` or `run` is low, `sclk` is low and neither strobe fires. The half-period counter restarts from zero, so the next frame begins with a full half period.
- R3: With `mode` = 1 (linear) and divisor N, each half period of `sclk` lasts N+1 bus cycles. The full period is 2(N+1) cycles with a 50% duty cycle, for N from 0 to 255.
- R4: With `mode` = 0 (power-of-two) and divisor N from 0 to 15, each half period lasts 2^N bus cycles, giving a full period of 2^(N+1).
- R5: In power-of-two mode, a divisor above 15 behaves exactly as 15 (half period 32768 cycles).
- R6: `lead_stb` is high for exactly one cycle: the first cycle in which `sclk` is high after a rise. `trail_stb` is high for exactly one cycle: the first cycle in which `sclk` is low after a toggle-driven fall. The two strobes are never high together.
- R7: `mode` and `divisor` are captured only on clock edges where `enable` is low. Changes made while `enable` is high do not affect the running divider.
- R8: Let edge k be the first clock edge that samples `enable` and `run` both high. The first rise of `sclk` then appears after edge k+H-1, where H is the half-period length. The fastest setting (linear, N=0) toggles every cycle, so `sclk` never exceeds half the bus clock.
- R9: If `run` falls while `sclk` is high, `sclk` returns low one cycle later and `trail_stb` does not fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Controller enable; configuration is captured while low |
| mode | input | 1 | Divide law: 1 = linear, 0 = power-of-two |
| divisor | input | 8 | Divisor N (exponent in power-of-two mode) |
| run | input | 1 | Frame-active request |
| sclk | output | 1 | Serial clock, idle low |
| lead_stb | output | 1 | One-cycle strobe after each rising edge of `sclk` |
| trail_stb | output | 1 | One-cycle strobe after each toggle-driven falling edge of `sclk` |

## Verification
The bench predicts the exact bus cycle of every strobe, covering the following cases:

- **Extremes of both laws.** Linear N=0 and N=255, and power-of-two N=0 and a clamped N=200. An off-by-one in the half-period count, or a missing clamp (which would wrap the exponent to 8), shifts every edge and is caught.
- **Divisor change while enabled.** A design that samples the divisor continuously would switch speed mid-stream.
- **Stop in the high phase.** A design that lets the clock finish its phase would emit a stray trailing strobe or leave `sclk` high.
- **Stop mid-count, then restart.** A counter that is not cleared would make the following frame's first edge arrive early.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_clkdiv_cfg.sv
// Captures mode/divisor while disabled and converts them to a half-period length.
module spi_clkdiv_cfg #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode,
  input  logic [DIV_W-1:0] divisor,
  output logic [CNT_W-1:0] half_len
);
  import spi_clkdiv_pkg::*;
  localparam int MAX_EXP = (1 << EXP_W) - 1;

  logic [EXP_W-1:0] exp_sel;
  logic [CNT_W-1:0] len_next;

  always_comb begin
    // Exponents above the field range are clamped (R5)
    if (divisor > DIV_W'(MAX_EXP)) exp_sel = EXP_W'(MAX_EXP);
    else                           exp_sel = divisor[EXP_W-1:0];
    if (div_mode_e'(mode) == DIV_LINEAR)
      len_next = CNT_W'(divisor) + CNT_W'(1);
    else
      len_next = CNT_W'(1) << exp_sel;
  end

  // Configuration is latched only while the controller is off (R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_len <= CNT_W'(1);
    else if (!enable) half_len <= len_next;
  end
endmodule

// File: rtl/spi_clkdiv_timer.sv
// Half-period counter; raises tick on the last cycle of each half period.
module spi_clkdiv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] half_len,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = active && (cnt == half_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_clkdiv_edge.sv
// Serial clock register and edge strobes.
module spi_clkdiv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!active) begin
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= tick && !sclk;
      trail_stb <= tick && sclk;
      if (tick) sclk <= !sclk;
    end
  end
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode,
  input  logic [DIV_W-1:0] divisor,
  input  logic             run,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CNT_W   = (MAX_EXP + 1 > DIV_W + 1) ? MAX_EXP + 1 : DIV_W + 1;

  logic             active;
  logic             tick;
  logic [CNT_W-1:0] half_len;

  assign active = enable && run;

  spi_clkdiv_cfg #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .divisor(divisor), .half_len(half_len)
  );

  spi_clkdiv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .half_len(half_len), .tick(tick)
  );

  spi_clkdiv_edge u_edge (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );
endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic run,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  // R1: quiet outputs while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!sclk && !lead_stb && !trail_stb)
        else $error("reset outputs not quiet");
    end
  end

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && run) |=> (!sclk && !lead_stb && !trail_stb));

  p_rise_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lead_stb && !trail_stb));

  p_lead_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  p_trail_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |=> !trail_stb);

  p_fall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (trail_stb || $past(!(enable && run))));

  p_stop_no_trail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !run) |=> (!sclk && !trail_stb));
endmodule

bind spi_clkdiv spi_clkdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
  .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/spi_clkdiv_bench.sv
`timescale 1ns/1ps
module spi_clkdiv_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       mode = 1'b1;
  logic [7:0] divisor = 8'd0;
  logic       run = 1'b0;
  logic       sclk, lead_stb, trail_stb;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  int exp_cyc[$];
  bit exp_lead[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_clkdiv u_spi_clkdiv (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .divisor(divisor), .run(run), .sclk(sclk),
    .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops expected edges as strobes appear (R3, R4, R6, R8)
  always @(negedge clk) begin
    if (rst_n && !done && (lead_stb || trail_stb)) begin
      check(!(lead_stb && trail_stb), "R6 both strobes", 1, 0);
      if (exp_cyc.size() == 0) begin
        check(1'b0, "R2 unexpected strobe", cyc, -1);
      end else begin
        int  ec;
        bit  el;
        ec = exp_cyc.pop_front();
        el = exp_lead.pop_front();
        check(cyc == ec, "R3/R4/R8 edge cycle", cyc, ec);
        check(lead_stb == el, "R6 strobe kind", int'(lead_stb), int'(el));
        check(sclk == el, "R6 sclk level at strobe", int'(sclk), int'(el));
      end
    end
  end

  task automatic configure(input bit m, input int n);
    @(negedge clk);
    enable  = 1'b0;
    mode    = m;
    divisor = 8'(n);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  // Driver: pushes expected edge cycles, runs, then stops (R9)
  task automatic burst(input int h, input int n, input int extra, input string tag);
    int c0;
    @(negedge clk);
    c0  = cyc;
    run = 1'b1;
    for (int i = 0; i < n; i++) begin
      exp_cyc.push_back(c0 + (i + 1) * h);
      exp_lead.push_back(i % 2 == 0);
    end
    do @(negedge clk); while (cyc < c0 + n * h);
    repeat (extra) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R9 sclk low after stop", int'(sclk), 0);
    check(exp_cyc.size() == 0, tag, exp_cyc.size(), 0);
    exp_cyc.delete();
    exp_lead.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sclk && !lead_stb && !trail_stb, "R1 reset quiet",
          int'({sclk, lead_stb, trail_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8/R3: fastest linear setting toggles every cycle
    configure(1'b1, 0);
    burst(1, 4, 0, "R8 missing edges (lin N=0)");
    // R3 linear N=3, odd count ends high -> R9
    configure(1'b1, 3);
    burst(4, 5, 0, "R3 missing edges (lin N=3)");
    // R3 linear N=255
    configure(1'b1, 255);
    burst(256, 2, 0, "R3 missing edges (lin N=255)");
    // R4 power-of-two settings
    configure(1'b0, 0);
    burst(1, 4, 0, "R4 missing edges (pow N=0)");
    configure(1'b0, 2);
    burst(4, 3, 0, "R4 missing edges (pow N=2)");
    configure(1'b0, 5);
    burst(32, 2, 0, "R4 missing edges (pow N=5)");
    // R5 clamp of oversized exponent
    configure(1'b0, 200);
    burst(32768, 2, 0, "R5 missing edges (pow N=200)");

    // R7: divisor change while enabled is ignored
    configure(1'b1, 1);
    @(negedge clk);
    divisor = 8'd9;
    repeat (2) @(negedge clk);
    burst(2, 3, 0, "R7 missing edges (old divisor kept)");
    configure(1'b1, 9);
    burst(10, 2, 0, "R7 missing edges (new divisor after disable)");

    // R2: stop mid-count, then restart with a full half period
    configure(1'b1, 5);
    burst(6, 2, 3, "R2 missing edges (before mid-count stop)");
    burst(6, 2, 0, "R2 missing edges (after restart)");

    // R2: run high but enable low gives no clock
    @(negedge clk);
    enable = 1'b0;
    run    = 1'b1;
    repeat (20) @(negedge clk);
    check(sclk == 1'b0, "R2 sclk low while disabled", int'(sclk), 0);
    run = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule